// File: doc/BRIEF.md
# Multichannel Conversion Sequence Controller

This block decides which entry of a 32-slot control table drives each analog-to-digital conversion, and the order in which the entries are used. Each slot holds an input channel number, a differential flag, a reference select and an end-of-sequence (EOS) mark. Software loads the table through a simple write port. It then chooses a first slot and one of four modes, and pulses a trigger.

The controller keeps a slot pointer that software cannot read. It fetches the selected entry and presents it to the converter with a one-cycle start request. On each conversion-done pulse from the converter it reports the slot that was just converted, so that a result store can file the sample. It then moves the pointer to the next slot, which wraps from the last slot to slot 0.

In the repeat modes the controller reloads the first slot and continues without a new trigger. This goes on until the enable input is cleared, which lets the running pass finish. A stop input abandons the run at once in every mode.

Top module: `conv_seq_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, busy, conv_start, res_valid and seq_done are all 0.
- R2: With mode 2'b00 (single), one trigger gives exactly one conversion of the slot at start_addr, whatever that slot's EOS mark. conv_slot, conv_chan, conv_diff and conv_ref show that slot's entry while conv_start is high. seq_done pulses once, in the same cycle as the result, and the block returns to idle.
- R3: With mode 2'b01 (sequence), slots are converted in rising order from start_addr. The sequence ends after converting the first slot whose EOS mark is set. seq_done pulses once, with the result of that slot.
- R4: When slot 31 has no EOS mark, the slot after 31 is slot 0 and the sequence continues.
- R5: With mode 2'b10 (repeat single), the start slot is converted again and again without a new trigger, with one seq_done pulse for each conversion. If enable is low when a conversion completes, the block goes idle after it.
- R6: With mode 2'b11 (repeat sequence), the pointer reloads from start_addr after each EOS slot and the next pass begins without a trigger. Clearing enable lets the current pass run to its EOS slot and then stops.
- R7: One cycle after each accepted conv_done, res_valid is high for one cycle and res_slot equals the slot just converted.
- R8: A cycle with stop high returns the block to idle in the next cycle, with no further conv_start. When stop and conv_done fall in the same cycle, stop wins: neither res_valid nor seq_done follows.
- R9: A trigger is ignored while busy is high, and it is also ignored when enable is low.
- R10: conv_start is a single-cycle pulse, is raised only while busy, and is not raised again until the pending conversion is done.
- R11: In sequence mode with no EOS mark anywhere in the table, conversions continue across the wrap until stop is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write enable for the control table |
| cfg_addr | input | 5 | Table slot to write |
| cfg_chan | input | 5 | Channel number to store |
| cfg_diff | input | 1 | Differential flag to store |
| cfg_ref | input | 3 | Reference select to store |
| cfg_eos | input | 1 | End-of-sequence mark to store |
| start_addr | input | 5 | First slot of a run |
| mode | input | 2 | 00 single, 01 sequence, 10 repeat single, 11 repeat sequence |
| enable | input | 1 | Permits triggers and continued repetition |
| trigger | input | 1 | Starts a run when idle and enabled |
| stop | input | 1 | Aborts the run immediately |
| conv_done | input | 1 | Converter finished the requested conversion |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_slot | output | 5 | Slot being converted |
| conv_chan | output | 5 | Channel of that slot |
| conv_diff | output | 1 | Differential flag of that slot |
| conv_ref | output | 3 | Reference select of that slot |
| res_valid | output | 1 | Result slot report strobe |
| res_slot | output | 5 | Slot whose conversion just completed |
| busy | output | 1 | A run is in progress |
| seq_done | output | 1 | Pulse at the end of a sequence or single conversion |

## Verification
The two functions that can meet in one cycle are the acceptance of a conversion-done pulse and an immediate abort by stop. The bench's converter stub raises stop in exactly the cycle in which it returns conv_done for the first slot of a sequence. The run must then show no res_valid, no seq_done and no second conv_start, and busy must be low in the following cycle. A second contest, a trigger that arrives while a sequence is running, is provoked in the middle of a run. It is judged by the slot stream staying identical to one single pass.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  // Mode encoding: bit 0 selects sequence stepping, bit 1 selects repetition.
  typedef enum logic [1:0] {
    MODE_SINGLE     = 2'b00,
    MODE_SEQ        = 2'b01,
    MODE_RPT_SINGLE = 2'b10,
    MODE_RPT_SEQ    = 2'b11
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;

  function automatic logic mode_steps(input seq_mode_e m);
    return m[0];
  endfunction

  function automatic logic mode_repeats(input seq_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/conv_seq_table.sv
module conv_seq_table #(
  parameter int DEPTH = 32,
  parameter int EW    = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);

  // Simple dual-port store with a registered read, suited to block RAM.
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/conv_seq_ptr.sv
module conv_seq_ptr #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= load_val;
    end else if (adv) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr = ptr_q;

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && ptr_q == LAST) |=> (ptr_q == '0));

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/conv_seq_issue.sv
module conv_seq_issue #(
  parameter int DEPTH  = 32,
  parameter int CHAN_W = 5,
  parameter int REF_W  = 3,
  localparam int AW    = $clog2(DEPTH),
  localparam int EW    = CHAN_W + REF_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [AW-1:0]     slot,
  input  logic [EW-1:0]     entry,
  output logic [AW-1:0]     cur_slot,
  output logic [CHAN_W-1:0] cur_chan,
  output logic              cur_diff,
  output logic [REF_W-1:0]  cur_ref,
  output logic              cur_eos
);

  // Entry packing: {eos, ref, diff, chan}
  localparam int DIFF_POS = CHAN_W;
  localparam int REF_LO   = CHAN_W + 1;
  localparam int EOS_POS  = EW - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_slot <= '0;
      cur_chan <= '0;
      cur_diff <= 1'b0;
      cur_ref  <= '0;
      cur_eos  <= 1'b0;
    end else if (issue) begin
      cur_slot <= slot;
      cur_chan <= entry[CHAN_W-1:0];
      cur_diff <= entry[DIFF_POS];
      cur_ref  <= entry[REF_LO +: REF_W];
      cur_eos  <= entry[EOS_POS];
    end
  end

endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
  import conv_seq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          enable,
  input  logic          trigger,
  input  logic          stop,
  input  logic          conv_done,
  input  logic          cur_eos,
  input  logic [AW-1:0] cur_slot,
  output logic          ptr_load,
  output logic          ptr_adv,
  output logic          rd_en,
  output logic          issue,
  output logic          conv_start,
  output logic          res_valid,
  output logic [AW-1:0] res_slot,
  output logic          seq_done,
  output logic          busy
);

  seq_state_e state_q, state_d;
  seq_mode_e  mode_q;
  logic       finish;
  logic       last;

  assign last = !mode_steps(mode_q) || cur_eos;

  always_comb begin
    state_d  = state_q;
    ptr_load = 1'b0;
    ptr_adv  = 1'b0;
    rd_en    = 1'b0;
    issue    = 1'b0;
    finish   = 1'b0;
    if (stop) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (trigger && enable) begin
            ptr_load = 1'b1;
            state_d  = ST_FETCH;
          end
        end
        ST_FETCH: begin
          rd_en   = 1'b1;
          state_d = ST_ISSUE;
        end
        ST_ISSUE: begin
          issue   = 1'b1;
          state_d = ST_WAIT;
        end
        ST_WAIT: begin
          if (conv_done) begin
            finish = 1'b1;
            if (last) begin
              if (mode_repeats(mode_q) && enable) begin
                ptr_load = 1'b1;
                state_d  = ST_FETCH;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              ptr_adv = 1'b1;
              state_d = ST_FETCH;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_SINGLE;
      conv_start <= 1'b0;
      res_valid  <= 1'b0;
      seq_done   <= 1'b0;
      res_slot   <= '0;
    end else begin
      state_q    <= state_d;
      conv_start <= issue;
      res_valid  <= finish;
      seq_done   <= finish && last;
      if (state_q == ST_IDLE && trigger && enable && !stop) begin
        mode_q <= seq_mode_e'(mode);
      end
      if (finish) begin
        res_slot <= cur_slot;
      end
    end
  end

  assign busy = (state_q != ST_IDLE);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!busy && !conv_start && !res_valid && !seq_done));

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);

  // R7
  res_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(conv_done));

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!busy && !res_valid && !seq_done && !conv_start));

  // R2
  done_with_result_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> res_valid);

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl #(
  parameter int N_SLOTS = 32,
  parameter int CHAN_W  = 5,
  parameter int REF_W   = 3,
  localparam int AW     = $clog2(N_SLOTS),
  localparam int EW     = CHAN_W + REF_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic              cfg_diff,
  input  logic [REF_W-1:0]  cfg_ref,
  input  logic              cfg_eos,
  input  logic [AW-1:0]     start_addr,
  input  logic [1:0]        mode,
  input  logic              enable,
  input  logic              trigger,
  input  logic              stop,
  input  logic              conv_done,
  output logic              conv_start,
  output logic [AW-1:0]     conv_slot,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              conv_diff,
  output logic [REF_W-1:0]  conv_ref,
  output logic              res_valid,
  output logic [AW-1:0]     res_slot,
  output logic              busy,
  output logic              seq_done
);

  logic [EW-1:0] wr_word;
  logic [EW-1:0] rd_word;
  logic [AW-1:0] ptr;
  logic          ptr_load;
  logic          ptr_adv;
  logic          rd_en;
  logic          issue;
  logic          cur_eos;

  assign wr_word = {cfg_eos, cfg_ref, cfg_diff, cfg_chan};

  conv_seq_table #(
    .DEPTH (N_SLOTS),
    .EW    (EW)
  ) u_table (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (wr_word),
    .re    (rd_en),
    .raddr (ptr),
    .rdata (rd_word)
  );

  conv_seq_ptr #(
    .DEPTH (N_SLOTS)
  ) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (ptr_load),
    .load_val (start_addr),
    .adv      (ptr_adv),
    .ptr      (ptr)
  );

  conv_seq_issue #(
    .DEPTH  (N_SLOTS),
    .CHAN_W (CHAN_W),
    .REF_W  (REF_W)
  ) u_issue (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue),
    .slot     (ptr),
    .entry    (rd_word),
    .cur_slot (conv_slot),
    .cur_chan (conv_chan),
    .cur_diff (conv_diff),
    .cur_ref  (conv_ref),
    .cur_eos  (cur_eos)
  );

  conv_seq_fsm #(
    .DEPTH (N_SLOTS)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .enable     (enable),
    .trigger    (trigger),
    .stop       (stop),
    .conv_done  (conv_done),
    .cur_eos    (cur_eos),
    .cur_slot   (conv_slot),
    .ptr_load   (ptr_load),
    .ptr_adv    (ptr_adv),
    .rd_en      (rd_en),
    .issue      (issue),
    .conv_start (conv_start),
    .res_valid  (res_valid),
    .res_slot   (res_slot),
    .seq_done   (seq_done),
    .busy       (busy)
  );

endmodule

// File: tb/tb_conv_seq_ctrl.sv
module tb_conv_seq_ctrl;

  localparam int N   = 32;
  localparam int AW  = 5;
  localparam int CW  = 5;
  localparam int RW  = 3;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_chan = '0;
  logic cfg_diff = 1'b0;
  logic [RW-1:0] cfg_ref = '0;
  logic cfg_eos = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0] mode = 2'b00;
  logic enable = 1'b1;
  logic trigger = 1'b0;
  logic stop = 1'b0;
  logic conv_done = 1'b0;
  logic conv_start;
  logic [AW-1:0] conv_slot;
  logic [CW-1:0] conv_chan;
  logic conv_diff;
  logic [RW-1:0] conv_ref;
  logic res_valid;
  logic [AW-1:0] res_slot;
  logic busy;
  logic seq_done;

  always #5 clk = ~clk;

  conv_seq_ctrl dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_chan(cfg_chan), .cfg_diff(cfg_diff), .cfg_ref(cfg_ref),
    .cfg_eos(cfg_eos), .start_addr(start_addr), .mode(mode),
    .enable(enable), .trigger(trigger), .stop(stop), .conv_done(conv_done),
    .conv_start(conv_start), .conv_slot(conv_slot), .conv_chan(conv_chan),
    .conv_diff(conv_diff), .conv_ref(conv_ref), .res_valid(res_valid),
    .res_slot(res_slot), .busy(busy), .seq_done(seq_done)
  );

  // Bench copy of the table contents
  int m_chan [N];
  int m_diff [N];
  int m_ref  [N];
  int m_eos  [N];

  int exp_start [$];
  int exp_res   [$];

  int n_checks = 0;
  int n_fail   = 0;
  int starts_seen = 0;
  int res_seen    = 0;
  int done_seen   = 0;
  bit pending = 1'b0;
  int cnt = 0;
  int cur = 0;
  bit stop_req = 1'b0;
  bit collide_req = 1'b0;
  bit collide_used = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Converter stub, scoreboard monitor and stop driver
  initial begin
    forever begin
      @(negedge clk);
      if (res_valid) begin
        res_seen++;
        if (exp_res.size() == 0) begin
          chk(1'b0, "R7", "unexpected res_valid slot", int'(res_slot), -1);
        end else begin
          int e;
          e = exp_res.pop_front();
          chk(int'(res_slot) == e, "R7", "res_slot", int'(res_slot), e);
        end
      end
      if (seq_done) done_seen++;
      conv_done = 1'b0;
      stop = stop_req;
      if (conv_start) begin
        starts_seen++;
        cur = int'(conv_slot);
        if (exp_start.size() == 0) begin
          chk(1'b0, "R10", "unexpected conv_start slot", cur, -1);
        end else begin
          int e;
          e = exp_start.pop_front();
          chk(cur == e, "R3", "conv_slot order", cur, e);
          chk(int'(conv_chan) == m_chan[cur], "R2", "conv_chan", int'(conv_chan), m_chan[cur]);
          chk(int'(conv_diff) == m_diff[cur], "R2", "conv_diff", int'(conv_diff), m_diff[cur]);
          chk(int'(conv_ref) == m_ref[cur], "R2", "conv_ref", int'(conv_ref), m_ref[cur]);
        end
        pending = 1'b1;
        cnt = LAT;
      end else if (pending) begin
        if (stop_req) begin
          pending = 1'b0;
        end else if (cnt > 1) begin
          cnt--;
        end else begin
          conv_done = 1'b1;
          pending = 1'b0;
          if (collide_req && !collide_used) begin
            collide_used = 1'b1;
            stop = 1'b1;
          end else begin
            exp_res.push_back(cur);
          end
        end
      end
    end
  end

  initial begin
    #1500000;
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    report();
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic write_entry(input int s, input int ch, input int df,
                             input int rf, input int eo);
    step();
    cfg_we = 1'b1;
    cfg_addr = AW'(s);
    cfg_chan = CW'(ch);
    cfg_diff = df[0];
    cfg_ref = RW'(rf);
    cfg_eos = eo[0];
    m_chan[s] = ch; m_diff[s] = df; m_ref[s] = rf; m_eos[s] = eo;
    step();
    cfg_we = 1'b0;
  endtask

  // Expected slot stream for 'passes' passes of a run
  task automatic plan(input int s0, input int md, input int passes);
    for (int p = 0; p < passes; p++) begin
      if (md % 2 == 0) begin
        exp_start.push_back(s0);
      end else begin
        int s;
        s = s0;
        for (int k = 0; k < N; k++) begin
          exp_start.push_back(s);
          if (m_eos[s] != 0) break;
          s = (s + 1) % N;
        end
      end
    end
  endtask

  task automatic fire(input int s0, input int md);
    step();
    start_addr = AW'(s0);
    mode = 2'(md);
    trigger = 1'b1;
    step();
    trigger = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy && !pending) break;
    end
    repeat (3) @(negedge clk);
    step();
    chk(busy == 1'b0, req, "busy after run", int'(busy), 0);
    chk(exp_start.size() == 0, req, "missing conversions", exp_start.size(), 0);
    chk(exp_res.size() == 0, req, "missing results", exp_res.size(), 0);
  endtask

  initial begin
    int d0;
    int s0;
    int r0;
    repeat (3) @(posedge clk);
    #2;
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(conv_start == 1'b0, "R1", "conv_start in reset", int'(conv_start), 0);
    chk(res_valid == 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);
    chk(seq_done == 1'b0, "R1", "seq_done in reset", int'(seq_done), 0);
    rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      write_entry(i, (i * 7 + 3) % 32, (i % 3 == 0) ? 1 : 0, i % 8,
                  (i == 1 || i == 4 || i == 7 || i == 12) ? 1 : 0);
    end

    // R2: single on a slot without EOS, then on a slot with EOS
    d0 = done_seen; s0 = starts_seen;
    plan(3, 0, 1);
    fire(3, 0);
    wait_idle("R2");
    chk(starts_seen - s0 == 1, "R2", "single conversions", starts_seen - s0, 1);
    chk(done_seen - d0 == 1, "R2", "single seq_done", done_seen - d0, 1);
    d0 = done_seen;
    plan(12, 0, 1);
    fire(12, 0);
    wait_idle("R2");
    chk(done_seen - d0 == 1, "R2", "single seq_done at eos slot", done_seen - d0, 1);

    // R3: sequence 2,3,4
    d0 = done_seen; s0 = starts_seen;
    plan(2, 1, 1);
    fire(2, 1);
    wait_idle("R3");
    chk(starts_seen - s0 == 3, "R3", "sequence length", starts_seen - s0, 3);
    chk(done_seen - d0 == 1, "R3", "sequence seq_done", done_seen - d0, 1);

    // R4: wrap 30,31,0,1
    d0 = done_seen; s0 = starts_seen;
    plan(30, 1, 1);
    fire(30, 1);
    wait_idle("R4");
    chk(starts_seen - s0 == 4, "R4", "wrapped sequence length", starts_seen - s0, 4);
    chk(done_seen - d0 == 1, "R4", "wrapped seq_done", done_seen - d0, 1);

    // R9: trigger while busy is ignored
    d0 = done_seen; s0 = starts_seen;
    plan(8, 1, 1);
    fire(8, 1);
    repeat (10) step();
    fire(2, 1);
    wait_idle("R9");
    chk(starts_seen - s0 == 5, "R9", "conversions with busy trigger", starts_seen - s0, 5);
    chk(done_seen - d0 == 1, "R9", "seq_done with busy trigger", done_seen - d0, 1);

    // R9: trigger with enable low is ignored
    s0 = starts_seen;
    step();
    enable = 1'b0;
    fire(2, 1);
    repeat (10) step();
    chk(busy == 1'b0, "R9", "busy after disabled trigger", int'(busy), 0);
    chk(starts_seen == s0, "R9", "starts after disabled trigger", starts_seen - s0, 0);
    enable = 1'b1;

    // R5: repeat single on slot 9, enable cleared after third start
    d0 = done_seen; s0 = starts_seen;
    plan(9, 2, 3);
    fire(9, 2);
    wait (starts_seen >= s0 + 3);
    step();
    enable = 1'b0;
    wait_idle("R5");
    chk(starts_seen - s0 == 3, "R5", "repeat single conversions", starts_seen - s0, 3);
    chk(done_seen - d0 == 3, "R5", "repeat single seq_done", done_seen - d0, 3);
    enable = 1'b1;

    // R6: repeat sequence 5,6,7; enable cleared during third pass
    d0 = done_seen; s0 = starts_seen;
    plan(5, 3, 3);
    fire(5, 3);
    wait (starts_seen >= s0 + 7);
    step();
    enable = 1'b0;
    wait_idle("R6");
    chk(starts_seen - s0 == 9, "R6", "repeat sequence conversions", starts_seen - s0, 9);
    chk(done_seen - d0 == 3, "R6", "repeat sequence seq_done", done_seen - d0, 3);
    enable = 1'b1;

    // R8: stop in the same cycle as conv_done
    d0 = done_seen; s0 = starts_seen; r0 = res_seen;
    collide_req = 1'b1;
    exp_start.push_back(2);
    fire(2, 1);
    repeat (25) step();
    chk(busy == 1'b0, "R8", "busy after collision", int'(busy), 0);
    chk(res_seen == r0, "R8", "res_valid after collision", res_seen - r0, 0);
    chk(done_seen == d0, "R8", "seq_done after collision", done_seen - d0, 0);
    chk(starts_seen - s0 == 1, "R8", "starts after collision", starts_seen - s0, 1);

    // R11: no EOS anywhere, runs across wrap until stop
    write_entry(1, m_chan[1], m_diff[1], m_ref[1], 0);
    write_entry(4, m_chan[4], m_diff[4], m_ref[4], 0);
    write_entry(7, m_chan[7], m_diff[7], m_ref[7], 0);
    write_entry(12, m_chan[12], m_diff[12], m_ref[12], 0);
    d0 = done_seen; s0 = starts_seen;
    for (int k = 0; k < 40; k++) exp_start.push_back(k % N);
    fire(0, 1);
    wait (starts_seen >= s0 + 40);
    step();
    stop_req = 1'b1;
    step();
    stop_req = 1'b0;
    chk(busy == 1'b0, "R8", "busy after stop", int'(busy), 0);
    repeat (20) step();
    chk(starts_seen - s0 == 40, "R11", "conversions before stop", starts_seen - s0, 40);
    chk(done_seen == d0, "R11", "no seq_done without eos", done_seen - d0, 0);
    chk(exp_res.size() == 0, "R7", "unreported results", exp_res.size(), 0);

    report();
  end

endmodule